// File: doc/BRIEF.md
# Privileged Control Register File

This block holds the bank of internal control registers a processor core uses in its privileged mode. A single request port carries an index, a write flag and write data. The block answers one cycle later with read data and a fault flag. Each index has a fixed write rule:

- store the whole value;
- store only a masked subset of bits;
- clear on any write;
- refuse the write (read-only);
- refuse the read (write-only);
- turn the write into a command for the translation buffers.

A live cycle count enters on its own input. A read of the counter register merges that count with stored upper bits. Hardware status (interrupt identifier, memory-management status, exception summary and mask) is loaded through a separate status port. While the core runs down a speculative path, all writes are dropped. Dropped writes raise no fault and leave no trace.

Index map:

| Index | Rule |
|---|---|
| 0..7 | Scratch, full write |
| 8 | Vector base, full write |
| 9 | Exception address, full write except bit 1 |
| 10, 11 | Trap request and trap enable |
| 12 | Priority level |
| 13, 14 | Instruction mode and data mode |
| 15 | Control/status |
| 16, 17 | Cache mode and miss-buffer mode |
| 18, 19 | Instruction and data address-space number |
| 20, 21 | Exception summary and mask |
| 22, 23 | Instruction and data page-table base |
| 24 | Machine control/status, full write |
| 25 | Cycle counter |
| 26, 27 | Interrupt identifier and memory-management status, read-only |
| 28 | Invalidate all instruction translations, write-only |
| 29 | Invalidate all data translations, write-only |
| 30 | Invalidate one data translation, write-only |
| 31..63 | Undefined |

Top module: `cpr_file`

## Requirements
- R1: After reset, every stored register reads zero, with two exceptions. The machine control/status register (index 24) reads 0x6. Scratch index 7 reads `cpu_id_i` zero-extended, loaded on the first clock after reset is released.
- R2: A write to a full-write index (0..8, 24) stores the whole 64-bit value. A read returns the stored value on `rdata_o` one cycle after the request. Writes return `rdata_o` = 0.
- R3: Writes keep only these bits:
  - exception address: every bit except bit 1;
  - trap request and enable: 0xf;
  - priority: 0x1f;
  - both mode registers: 0x18;
  - control/status: 0xffffff0300;
  - cache and miss-buffer mode: 0x3f;
  - instruction address space: 0x7f0;
  - data address space: bits 63..57 only;
  - both page-table bases: bits 63..30 only.
- R4: Any write to index 20 or 21 clears that register to zero, whatever the data. The status port (select 2 = index 20, select 3 = index 21) sets it.
- R5: A write to index 26 or 27 raises `fault_o` and leaves the register unchanged. The status port loads them (select 0 = index 26, select 1 = index 27).
- R6: A read of index 25 returns bits 63..32 of the last value written there, followed by `cycle_i` as sampled at the request edge.
- R7: A read of a write-only index (28..30) or an undefined index (31..63) returns zero with `fault_o` set. So does a write to an undefined index.
- R8: A write to index 28, 29 or 30 pulses bit 0, 1 or 2 of `tlb_cmd_o` for exactly one cycle and raises no fault. For index 30, `tlb_va_o` carries the written data in that cycle. Otherwise `tlb_va_o` is zero.
- R9: While `spec_i` is high, a write has no effect: no register changes, no fault, no command.
- R10: In a cycle after no request, `rdata_o`, `fault_o` and `tlb_cmd_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_id_i | input | 8 | Processor number loaded into scratch 7 after reset |
| cycle_i | input | 32 | Live cycle count |
| spec_i | input | 1 | Core is speculating; writes are dropped |
| req_valid_i | input | 1 | Request present |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_idx_i | input | 6 | Register index |
| req_wdata_i | input | 64 | Write data |
| stat_we_i | input | 1 | Hardware status load |
| stat_sel_i | input | 2 | Status target: 0 irq id, 1 mm status, 2 exc summary, 3 exc mask |
| stat_data_i | input | 64 | Status value |
| rdata_o | output | 64 | Read data, registered |
| fault_o | output | 1 | Illegal access, registered |
| tlb_cmd_o | output | 3 | One-cycle translation-buffer command strobes |
| tlb_va_o | output | 64 | Address for single-entry invalidate |

## Verification
Every response appears exactly one clock after the edge that samples the request. This holds for `rdata_o`, `fault_o`, `tlb_cmd_o` and `tlb_va_o` alike. A stored write is visible to a read issued on the very next cycle. The bench drives each request on a falling edge and samples all four outputs on the following falling edge, half a cycle after the register stage has updated. It then advances its own model of the register contents. An idle cycle follows each command to confirm the strobe lasts only one cycle. Status-port loads take effect at the next edge and are read back in a later request.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
  localparam int DW      = 64;
  localparam int IW      = 6;
  localparam int CPU_W   = 8;
  localparam int CYC_W   = DW / 2;
  localparam int N_SCR   = 8;
  localparam int SCR_CPU = N_SCR - 1;

  localparam int I_VBASE = 8;
  localparam int I_EXCA  = 9;
  localparam int I_TREQ  = 10;
  localparam int I_TEN   = 11;
  localparam int I_PRIO  = 12;
  localparam int I_IMODE = 13;
  localparam int I_DMODE = 14;
  localparam int I_CTLST = 15;
  localparam int I_CMODE = 16;
  localparam int I_MMODE = 17;
  localparam int I_IASN  = 18;
  localparam int I_DASN  = 19;
  localparam int I_XSUM  = 20;
  localparam int I_XMSK  = 21;
  localparam int I_IPTB  = 22;
  localparam int I_DPTB  = 23;
  localparam int I_MCSR  = 24;
  localparam int I_CYC   = 25;
  localparam int I_INTID = 26;
  localparam int I_MMST  = 27;
  localparam int N_STORE = 28;
  localparam int SW      = $clog2(N_STORE);

  localparam int I_IFLUSH = 28;
  localparam int I_DFLUSH = 29;
  localparam int I_DFLONE = 30;
  localparam int N_CMD    = I_DFLONE - I_IFLUSH + 1;
  localparam int CMD_ONE  = I_DFLONE - I_IFLUSH;

  localparam logic [DW-1:0] MCSR_RST = DW'(6);

  typedef enum logic [2:0] {
    K_NONE, K_RW, K_CC, K_CLR, K_RO, K_CTL
  } kind_e;

  typedef struct packed {
    kind_e           kind;
    logic [DW-1:0]   mask;
  } attr_t;

  function automatic attr_t reg_attr(input logic [IW-1:0] idx);
    attr_t a;
    a.kind = K_NONE;
    a.mask = '0;
    if (int'(idx) < N_SCR) begin
      a.kind = K_RW;
      a.mask = '1;
    end else begin
      case (idx)
        IW'(I_VBASE), IW'(I_MCSR): begin a.kind = K_RW; a.mask = '1; end
        IW'(I_EXCA):  begin a.kind = K_RW; a.mask = ~DW'(64'h2); end
        IW'(I_TREQ), IW'(I_TEN): begin a.kind = K_RW; a.mask = DW'(64'hf); end
        IW'(I_PRIO):  begin a.kind = K_RW; a.mask = DW'(64'h1f); end
        IW'(I_IMODE), IW'(I_DMODE): begin a.kind = K_RW; a.mask = DW'(64'h18); end
        IW'(I_CTLST): begin a.kind = K_RW; a.mask = DW'(64'hff_ffff_0300); end
        IW'(I_CMODE), IW'(I_MMODE): begin a.kind = K_RW; a.mask = DW'(64'h3f); end
        IW'(I_IASN):  begin a.kind = K_RW; a.mask = DW'(64'h7f0); end
        IW'(I_DASN):  begin a.kind = K_RW; a.mask = 64'hfe00_0000_0000_0000; end
        IW'(I_IPTB), IW'(I_DPTB): begin a.kind = K_RW; a.mask = 64'hffff_ffff_c000_0000; end
        IW'(I_CYC):   begin a.kind = K_CC; a.mask = '1; end
        IW'(I_XSUM), IW'(I_XMSK): a.kind = K_CLR;
        IW'(I_INTID), IW'(I_MMST): a.kind = K_RO;
        IW'(I_IFLUSH), IW'(I_DFLUSH), IW'(I_DFLONE): a.kind = K_CTL;
        default: a.kind = K_NONE;
      endcase
    end
    return a;
  endfunction

  function automatic int stat_index(input logic [1:0] sel);
    case (sel)
      2'd0:    return I_INTID;
      2'd1:    return I_MMST;
      2'd2:    return I_XSUM;
      default: return I_XMSK;
    endcase
  endfunction
endpackage

// File: rtl/cpr_decode.sv
module cpr_decode
  import cpr_pkg::*;
(
  input  logic            valid_i,
  input  logic            we_i,
  input  logic            spec_i,
  input  logic [IW-1:0]   idx_i,
  input  logic [DW-1:0]   wdata_i,
  output kind_e           kind_o,
  output logic            store_we_o,
  output logic [DW-1:0]   wval_o,
  output logic            fault_o,
  output logic [N_CMD-1:0] cmd_o
);
  attr_t attr;
  logic  wr_go;

  assign attr   = reg_attr(idx_i);
  assign kind_o = attr.kind;
  assign wr_go  = valid_i && we_i && !spec_i;

  always_comb begin
    store_we_o = 1'b0;
    wval_o     = '0;
    unique case (attr.kind)
      K_RW, K_CC: begin store_we_o = wr_go; wval_o = wdata_i & attr.mask; end
      K_CLR:      begin store_we_o = wr_go; wval_o = '0; end
      default:    ;
    endcase
  end

  // illegal: store to read-only/undefined, fetch from write-only/undefined
  assign fault_o = (wr_go && (attr.kind == K_RO || attr.kind == K_NONE)) ||
                   (valid_i && !we_i && (attr.kind == K_CTL || attr.kind == K_NONE));

  for (genvar c = 0; c < N_CMD; c++) begin : g_cmd
    assign cmd_o[c] = wr_go && (attr.kind == K_CTL) && (idx_i == IW'(I_IFLUSH + c));
  end
endmodule

// File: rtl/cpr_bank.sv
module cpr_bank
  import cpr_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [CPU_W-1:0]            cpu_id_i,
  input  logic                        we_i,
  input  logic [IW-1:0]               idx_i,
  input  logic [DW-1:0]               wval_i,
  input  logic                        stat_we_i,
  input  logic [1:0]                  stat_sel_i,
  input  logic [DW-1:0]               stat_data_i,
  output logic [N_STORE-1:0][DW-1:0]  regs_o
);
  logic init_q;
  int   stat_tgt;

  assign stat_tgt = stat_index(stat_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) init_q <= 1'b1;
    else         init_q <= 1'b0;
  end

  for (genvar g = 0; g < N_STORE; g++) begin : g_reg
    localparam bit IS_HW  = (g == I_INTID) || (g == I_MMST) || (g == I_XSUM) || (g == I_XMSK);
    localparam bit IS_CPU = (g == SCR_CPU);
    localparam logic [DW-1:0] RST_V = (g == I_MCSR) ? MCSR_RST : '0;
    logic [DW-1:0] q;
    logic          hw_hit, bus_hit, id_load;

    assign hw_hit  = IS_HW && stat_we_i && (stat_tgt == g);
    assign bus_hit = we_i && (idx_i == IW'(g));
    assign id_load = IS_CPU && init_q;

    // hardware status load wins over a clearing bus write in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q <= RST_V;
      else if (id_load) q <= DW'(cpu_id_i);
      else if (hw_hit)  q <= stat_data_i;
      else if (bus_hit) q <= wval_i;
    end
    assign regs_o[g] = q;
  end

  AST_RO_HOLD_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_we_i |=> $stable(regs_o[I_INTID])); // R5
  AST_RO_HOLD_MM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_we_i |=> $stable(regs_o[I_MMST])); // R5
  AST_EXCA_BIT1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_o[I_EXCA][1] == 1'b0); // R3
  AST_PRIO_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regs_o[I_PRIO] & ~DW'(64'h1f)) == '0); // R3
endmodule

// File: rtl/cpr_resp.sv
module cpr_resp
  import cpr_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic                        we_i,
  input  kind_e                       kind_i,
  input  logic [IW-1:0]               idx_i,
  input  logic [DW-1:0]               wdata_i,
  input  logic [CYC_W-1:0]            cycle_i,
  input  logic [N_STORE-1:0][DW-1:0]  regs_i,
  input  logic                        fault_i,
  input  logic [N_CMD-1:0]            cmd_i,
  output logic [DW-1:0]               rdata_o,
  output logic                        fault_o,
  output logic [N_CMD-1:0]            cmd_o,
  output logic [DW-1:0]               va_o
);
  logic [DW-1:0] rd_v;

  always_comb begin
    rd_v = '0;
    unique case (kind_i)
      K_RW, K_CLR, K_RO: rd_v = regs_i[idx_i[SW-1:0]];
      K_CC:              rd_v = {regs_i[I_CYC][DW-1:CYC_W], cycle_i};
      default:           rd_v = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      fault_o <= 1'b0;
      cmd_o   <= '0;
      va_o    <= '0;
    end else begin
      rdata_o <= (valid_i && !we_i && !fault_i) ? rd_v : '0;
      fault_o <= fault_i;
      cmd_o   <= cmd_i;
      va_o    <= cmd_i[CMD_ONE] ? wdata_i : '0;
    end
  end
endmodule

// File: rtl/cpr_file.sv
module cpr_file
  import cpr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CPU_W-1:0]  cpu_id_i,
  input  logic [CYC_W-1:0]  cycle_i,
  input  logic              spec_i,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [IW-1:0]     req_idx_i,
  input  logic [DW-1:0]     req_wdata_i,
  input  logic              stat_we_i,
  input  logic [1:0]        stat_sel_i,
  input  logic [DW-1:0]     stat_data_i,
  output logic [DW-1:0]     rdata_o,
  output logic              fault_o,
  output logic [N_CMD-1:0]  tlb_cmd_o,
  output logic [DW-1:0]     tlb_va_o
);
  kind_e                       kind;
  logic                        store_we, fault_c;
  logic [DW-1:0]               wval;
  logic [N_CMD-1:0]            cmd_c;
  logic [N_STORE-1:0][DW-1:0]  regs;

  cpr_decode u_dec (
    .valid_i    (req_valid_i),
    .we_i       (req_we_i),
    .spec_i     (spec_i),
    .idx_i      (req_idx_i),
    .wdata_i    (req_wdata_i),
    .kind_o     (kind),
    .store_we_o (store_we),
    .wval_o     (wval),
    .fault_o    (fault_c),
    .cmd_o      (cmd_c)
  );

  cpr_bank u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_id_i    (cpu_id_i),
    .we_i        (store_we),
    .idx_i       (req_idx_i),
    .wval_i      (wval),
    .stat_we_i   (stat_we_i),
    .stat_sel_i  (stat_sel_i),
    .stat_data_i (stat_data_i),
    .regs_o      (regs)
  );

  cpr_resp u_resp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (req_valid_i),
    .we_i    (req_we_i),
    .kind_i  (kind),
    .idx_i   (req_idx_i),
    .wdata_i (req_wdata_i),
    .cycle_i (cycle_i),
    .regs_i  (regs),
    .fault_i (fault_c),
    .cmd_i   (cmd_c),
    .rdata_o (rdata_o),
    .fault_o (fault_o),
    .cmd_o   (tlb_cmd_o),
    .va_o    (tlb_va_o)
  );

  AST_SPEC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_we_i && spec_i) |=> (!fault_o && tlb_cmd_o == '0)); // R9
  AST_SPEC_NO_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_we_i && spec_i && !stat_we_i) |=> $stable(regs)); // R9
  AST_FAULT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> rdata_o == '0); // R7
  AST_CMD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tlb_cmd_o)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!fault_o && rdata_o == '0 && tlb_cmd_o == '0)); // R10
endmodule

// File: tb/cpr_file_tb.sv
`timescale 1ns/1ps
module cpr_file_tb;
  localparam int K_NONE = 0, K_RW = 1, K_CC = 2, K_CLR = 3, K_RO = 4, K_CTL = 5;
  localparam logic [7:0] CPU_ID = 8'h5a;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0]  cpu_id_i = CPU_ID;
  logic [31:0] cycle_i = '0;
  logic        spec_i = 1'b0, req_valid_i = 1'b0, req_we_i = 1'b0;
  logic [5:0]  req_idx_i = '0;
  logic [63:0] req_wdata_i = '0;
  logic        stat_we_i = 1'b0;
  logic [1:0]  stat_sel_i = '0;
  logic [63:0] stat_data_i = '0;
  logic [63:0] rdata_o, tlb_va_o;
  logic        fault_o;
  logic [2:0]  tlb_cmd_o;

  int checks = 0, errors = 0;
  logic [63:0] mdl [0:27];
  bit done = 0;

  always #10 clk_i = ~clk_i;

  cpr_file u_dut (.*);

  function automatic int kind_of(int i);
    if (i < 9 || i == 24) return K_RW;
    if (i >= 9 && i <= 19) return K_RW;
    if (i == 22 || i == 23) return K_RW;
    if (i == 25) return K_CC;
    if (i == 20 || i == 21) return K_CLR;
    if (i == 26 || i == 27) return K_RO;
    if (i >= 28 && i <= 30) return K_CTL;
    return K_NONE;
  endfunction

  function automatic logic [63:0] mask_of(int i);
    case (i)
      9:       return ~64'h2;
      10, 11:  return 64'hf;
      12:      return 64'h1f;
      13, 14:  return 64'h18;
      15:      return 64'hff_ffff_0300;
      16, 17:  return 64'h3f;
      18:      return 64'h7f0;
      19:      return 64'hfe00_0000_0000_0000;
      22, 23:  return 64'hffff_ffff_c000_0000;
      default: return '1;
    endcase
  endfunction

  function automatic string tag_of(int k, bit we, bit sp);
    if (we && sp) return "R9";
    if (k == K_NONE || (k == K_CTL && !we)) return "R7";
    if (k == K_RO) return we ? "R5" : "R5 read";
    if (k == K_CC) return "R6";
    if (k == K_CLR) return "R4";
    if (k == K_CTL) return "R8";
    return "R3";
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic op(bit we, int idx, logic [63:0] d, bit sp, logic [31:0] cyc, string tag);
    int k;
    bit wr, e_fault;
    logic [63:0] e_rd, e_va;
    logic [2:0]  e_cmd;
    k  = kind_of(idx);
    wr = we && !sp;
    e_fault = we ? (wr && (k == K_RO || k == K_NONE)) : (k == K_CTL || k == K_NONE);
    e_rd = '0;
    if (!we && !e_fault) e_rd = (k == K_CC) ? {mdl[25][63:32], cyc} : mdl[idx];
    e_cmd = (wr && k == K_CTL) ? 3'(1 << (idx - 28)) : 3'b0;
    e_va  = (wr && idx == 30) ? d : '0;
    req_valid_i = 1'b1; req_we_i = we; req_idx_i = 6'(idx);
    req_wdata_i = d; spec_i = sp; cycle_i = cyc;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(rdata_o == e_rd, tag, $sformatf("rdata idx%0d", idx), rdata_o, e_rd);
    chk(fault_o == e_fault, tag, $sformatf("fault idx%0d", idx), 64'(fault_o), 64'(e_fault));
    chk(tlb_cmd_o == e_cmd, tag, $sformatf("cmd idx%0d", idx), 64'(tlb_cmd_o), 64'(e_cmd));
    chk(tlb_va_o == e_va, tag, $sformatf("va idx%0d", idx), tlb_va_o, e_va);
    if (wr && (k == K_RW || k == K_CC)) mdl[idx] = d & mask_of(idx);
    if (wr && k == K_CLR) mdl[idx] = '0;
  endtask

  task automatic idle(string tag);
    @(negedge clk_i);
    chk(rdata_o == '0 && !fault_o && tlb_cmd_o == '0, tag, "idle quiet",
        {rdata_o[60:0], fault_o, tlb_cmd_o[1:0]} | 64'(tlb_cmd_o[2]), 64'h0);
  endtask

  task automatic stat(int sel, logic [63:0] d);
    stat_we_i = 1'b1; stat_sel_i = 2'(sel); stat_data_i = d;
    @(negedge clk_i);
    stat_we_i = 1'b0;
    mdl[26 + ((sel + 2) % 4 == 0 ? 0 : 0) + (sel == 0 ? 0 : sel == 1 ? 1 : sel == 2 ? -6 : -5)] = d;
  endtask

  initial begin
    #4ms;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 28; i++) mdl[i] = '0;
    mdl[24] = 64'h6;
    mdl[7]  = 64'(CPU_ID);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset contents
    for (int i = 0; i < 28; i++) op(1'b0, i, '0, 1'b0, 32'h1111_0000, "R1");
    idle("R10");

    // R2 full writes and immediate read-back
    op(1'b1, 3, 64'hdead_beef_0123_4567, 1'b0, '0, "R2");
    op(1'b0, 3, '0, 1'b0, '0, "R2");
    op(1'b1, 24, 64'h8000_0000_0000_0001, 1'b0, '0, "R2");
    op(1'b0, 24, '0, 1'b0, '0, "R2");

    // R3 masks: all-ones then read
    for (int i = 9; i <= 23; i++) begin
      if (i == 20 || i == 21) continue;
      op(1'b1, i, '1, 1'b0, '0, "R3");
      op(1'b0, i, '0, 1'b0, '0, "R3");
    end

    // R4 write-to-clear
    stat(2, 64'h0000_00ff_0000_1234);
    stat(3, 64'h5555_aaaa_0000_0001);
    op(1'b0, 20, '0, 1'b0, '0, "R4");
    op(1'b1, 20, '1, 1'b0, '0, "R4");
    op(1'b0, 20, '0, 1'b0, '0, "R4");
    op(1'b1, 21, 64'h7, 1'b0, '0, "R4");
    op(1'b0, 21, '0, 1'b0, '0, "R4");

    // R5 read-only
    stat(0, 64'h17);
    stat(1, 64'hffff_0000_abcd_0000);
    op(1'b1, 26, 64'h3, 1'b0, '0, "R5");
    op(1'b0, 26, '0, 1'b0, '0, "R5");
    op(1'b1, 27, '0, 1'b0, '0, "R5");
    op(1'b0, 27, '0, 1'b0, '0, "R5");

    // R6 cycle counter merge
    op(1'b1, 25, 64'hcafe_f00d_ffff_ffff, 1'b0, '0, "R6");
    op(1'b0, 25, '0, 1'b0, 32'h0bad_c0de, "R6");
    op(1'b0, 25, '0, 1'b0, 32'hffff_fffe, "R6");

    // R7 write-only and undefined
    op(1'b0, 28, '0, 1'b0, '0, "R7");
    op(1'b0, 30, '0, 1'b0, '0, "R7");
    op(1'b0, 31, '0, 1'b0, '0, "R7");
    op(1'b1, 63, '1, 1'b0, '0, "R7");

    // R8 command strobes, each followed by an idle cycle
    op(1'b1, 28, 64'h1, 1'b0, '0, "R8"); idle("R8");
    op(1'b1, 29, 64'h2, 1'b0, '0, "R8"); idle("R8");
    op(1'b1, 30, 64'h0000_7fff_e000_2000, 1'b0, '0, "R8"); idle("R8");

    // R9 speculative writes dropped
    op(1'b1, 5, 64'h1234, 1'b1, '0, "R9");
    op(1'b0, 5, '0, 1'b0, '0, "R9");
    op(1'b1, 26, '1, 1'b1, '0, "R9");
    op(1'b1, 29, '1, 1'b1, '0, "R9");
    op(1'b1, 40, '1, 1'b1, '0, "R9");
    op(1'b1, 20, '1, 1'b1, '0, "R9");

    // random mix
    for (int n = 0; n < 500; n++) begin
      int idx;
      bit we, sp;
      idx = $urandom_range(0, 40);
      we  = $urandom_range(0, 1);
      sp  = ($urandom_range(0, 7) == 0);
      op(we, idx, {$urandom, $urandom}, sp, $urandom, tag_of(kind_of(idx), we, sp));
      if ($urandom_range(0, 15) == 0) idle("R10");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule